// File: doc/BRIEF.md
# Lowest-Priority Arbitration Participant

This block is the receiving side of a two-line serial interrupt bus during the phase that picks one destination for a lowest-priority interrupt. A bus receiver supplies a cycle number and a qualifier. The qualifier marks each clock that carries one bus cycle. The block looks at the status the sender put on the bus in the status cycle. If lowest-priority delivery is requested and the local unit has a free interrupt slot, the block enters a contest.

The bus is wired-OR: a line reads asserted when any unit drives it. The contest is fought one bit per bus cycle, most significant bit first, in two rounds. The first round uses the inverted processor priority, so the numerically lowest priority survives. The second round uses the bus arbitration ID, where the highest ID survives. A unit that leaves a line released but reads it asserted has lost, and it stays silent from then on. The unit still standing at the end drives the acceptance code in the cycle after the tie-break. It raises a one-clock accept pulse and holds a win flag until the next message begins.

Top module: `lpa_participant`

## Requirements
- R1: Reset (`rst` high at a clock edge) clears all state. After reset, `win` and `accept` are 0, and `drv_en` is 0 in every later bus cycle until a new contest is entered.
- R2: The block enters the contest only if `slot_free` is 1 and `bus_in` equals 2'b11 in cycle 20. Otherwise it drives nothing in cycles 21 to 34, and `win` and `accept` stay 0.
- R3: In cycles 21 to 28 a contestant drives line 0 (`drv_en[0]`) with the inverse of one priority bit per cycle. Cycle 21 carries bit 7 and cycle 28 carries bit 0. Line 1 is released.
- R4: In cycles 29 to 32 a remaining contestant drives line 0 with one arbitration ID bit per cycle. Cycle 29 carries bit 3 and cycle 32 carries bit 0.
- R5: A contestant that reads `bus_in[0]` = 1 in a cycle in which it left line 0 released drops out. It drives nothing for the rest of cycles 21 to 33, and `win` stays 0.
- R6: `win` rises in the clock after cycle 32 if the block is still in the contest. It then holds until the next cycle 1 or reset.
- R7: In cycle 33 a winner drives `drv_en` = 2'b10 (line 1 asserted, line 0 released). A non-winner drives 2'b00 in cycle 33. Line 1 is driven in no other cycle.
- R8: `accept` is a pulse of exactly one clock. It comes in the clock that follows the cycle-33 clock, and only for a winner.
- R9: `drv_en` is 0 in cycles 1 to 20 and in cycle 34.
- R10: A valid cycle 1 clears `win` and the contest state. `win` is 0 from the clock after cycle 1.
- R11: Clocks with `cyc_valid` low change no state, and `drv_en` is 0 during them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high bus reset |
| cyc_num | input | 6 | Bus cycle number within the message (1 to 34) |
| cyc_valid | input | 1 | High on clocks that carry a bus cycle |
| prio | input | 8 | Current processor priority |
| arb_id | input | 4 | Bus arbitration ID used for tie-break |
| slot_free | input | 1 | Local unit can accept one more interrupt |
| bus_in | input | 2 | Sampled wired-OR bus lines |
| drv_en | output | 2 | Per-line drive enables (1 = assert line) |
| win | output | 1 | Block survived both arbitration rounds |
| accept | output | 1 | One-clock pulse after the acceptance status cycle |

## Verification
`drv_en` is combinational within a bus cycle. The bench sets the cycle number at the falling edge and checks the drive 1 ns later, before the rising edge that samples the bus. The bench's wired-OR model feeds that same drive back into `bus_in`. `win` is registered at the cycle-32 edge, so it is checked during cycle 33. `accept` is registered at the cycle-33 edge, so it is checked during the next clock, whether that is cycle 34 or an idle gap. It is checked again one clock later to confirm it has fallen. Clearing after cycle 1 is checked during cycle 2. The mid-contest reset is checked on the first bus cycle after reset is released.

// File: rtl/lpa_pkg.sv
package lpa_pkg;

    localparam int LPA_LINES = 2;
    localparam int LPA_IDX_W = 5;

    localparam logic [LPA_LINES-1:0] LPA_STAT_LOWEST = 2'b11;
    localparam logic [LPA_LINES-1:0] LPA_ACK_CODE    = 2'b10;

    typedef enum logic [2:0] {
        PH_OFF,
        PH_START,
        PH_STATUS,
        PH_PRIO,
        PH_TIE,
        PH_ACK,
        PH_IDLE
    } lpa_phase_e;

    typedef struct packed {
        lpa_phase_e            phase;
        logic [LPA_IDX_W-1:0]  idx;
        logic                  last;
    } lpa_slot_t;

    typedef struct packed {
        logic active;
        logic win;
        logic acc;
    } lpa_state_t;

    // contestant leaves the line released but sees it asserted
    function automatic logic lpa_drops(input logic active, input logic drove, input logic seen);
        return active & ~drove & seen;
    endfunction

    function automatic logic lpa_is_arb(input lpa_phase_e ph);
        return (ph == PH_PRIO) || (ph == PH_TIE);
    endfunction

endpackage

// File: rtl/lpa_phase_dec.sv
module lpa_phase_dec
    import lpa_pkg::*;
#(
    parameter int CNT_W      = 6,
    parameter int PRIO_W     = 8,
    parameter int ID_W       = 4,
    parameter int START_CYC  = 1,
    parameter int STATUS_CYC = 20
) (
    input  logic [CNT_W-1:0] cyc_num,
    input  logic             cyc_valid,
    output lpa_slot_t        slot
);

    localparam int PRIO_FIRST = STATUS_CYC + 1;
    localparam int ID_FIRST   = PRIO_FIRST + PRIO_W;
    localparam int ACK_CYC    = ID_FIRST + ID_W;
    localparam int IDLE_CYC   = ACK_CYC + 1;

    logic [CNT_W-1:0] prio_off;
    logic [CNT_W-1:0] id_off;

    always_comb begin
        prio_off = cyc_num - CNT_W'(PRIO_FIRST);
        id_off   = cyc_num - CNT_W'(ID_FIRST);
        slot     = '{phase: PH_OFF, idx: '0, last: 1'b0};
        if (cyc_valid) begin
            if (cyc_num == CNT_W'(START_CYC)) begin
                slot.phase = PH_START;
            end else if (cyc_num == CNT_W'(STATUS_CYC)) begin
                slot.phase = PH_STATUS;
            end else if (cyc_num >= CNT_W'(PRIO_FIRST) && cyc_num < CNT_W'(ID_FIRST)) begin
                slot.phase = PH_PRIO;
                slot.idx   = LPA_IDX_W'(PRIO_W - 1) - LPA_IDX_W'(prio_off);
            end else if (cyc_num >= CNT_W'(ID_FIRST) && cyc_num < CNT_W'(ACK_CYC)) begin
                slot.phase = PH_TIE;
                slot.idx   = LPA_IDX_W'(ID_W - 1) - LPA_IDX_W'(id_off);
                slot.last  = (id_off == CNT_W'(ID_W - 1));
            end else if (cyc_num == CNT_W'(ACK_CYC)) begin
                slot.phase = PH_ACK;
            end else if (cyc_num == CNT_W'(IDLE_CYC)) begin
                slot.phase = PH_IDLE;
            end
        end
    end

endmodule

// File: rtl/lpa_bit_pick.sv
module lpa_bit_pick
    import lpa_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]         val,
    input  logic [LPA_IDX_W-1:0] idx,
    output logic                 pick
);

    logic [W-1:0] hit;

    for (genvar i = 0; i < W; i++) begin : g_hit
        assign hit[i] = val[i] & (idx == LPA_IDX_W'(i));
    end

    assign pick = |hit;

endmodule

// File: rtl/lpa_elim.sv
module lpa_elim
    import lpa_pkg::*;
#(
    parameter int ARB_LINE = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  lpa_phase_e           phase,
    input  logic                 last,
    input  logic                 drive_bit,
    input  logic                 slot_free,
    input  logic [LPA_LINES-1:0] bus_in,
    output lpa_state_t           st
);

    logic drop;

    assign drop = lpa_drops(st.active, drive_bit, bus_in[ARB_LINE]);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st.acc <= 1'b0;
            case (phase)
                PH_START: begin
                    st.active <= 1'b0;
                    st.win    <= 1'b0;
                end
                PH_STATUS: begin
                    st.active <= slot_free && (bus_in == LPA_STAT_LOWEST);
                end
                PH_PRIO: begin
                    if (drop) st.active <= 1'b0;
                end
                PH_TIE: begin
                    if (drop) st.active <= 1'b0;
                    if (last) st.win <= st.active & ~drop;
                end
                PH_ACK: begin
                    st.acc <= st.win;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/lpa_participant.sv
module lpa_participant
    import lpa_pkg::*;
#(
    parameter int CNT_W      = 6,
    parameter int PRIO_W     = 8,
    parameter int ID_W       = 4,
    parameter int STATUS_CYC = 20,
    parameter int ARB_LINE   = 0,
    parameter bit LOW_WINS   = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  cyc_num,
    input  logic              cyc_valid,
    input  logic [PRIO_W-1:0] prio,
    input  logic [ID_W-1:0]   arb_id,
    input  logic              slot_free,
    input  logic [1:0]        bus_in,
    output logic [1:0]        drv_en,
    output logic              win,
    output logic              accept
);

    localparam int START_CYC  = 1;
    localparam int PRIO_FIRST = STATUS_CYC + 1;
    localparam int ID_FIRST   = PRIO_FIRST + PRIO_W;
    localparam int ACK_CYC    = ID_FIRST + ID_W;

    lpa_slot_t         slot;
    lpa_state_t        st;
    logic [PRIO_W-1:0] prio_key;
    logic              prio_pick;
    logic              id_pick;
    logic              want;
    logic              drive_bit;

    if (LOW_WINS) begin : g_low_wins
        assign prio_key = ~prio;
    end else begin : g_high_wins
        assign prio_key = prio;
    end

    lpa_phase_dec #(
        .CNT_W      (CNT_W),
        .PRIO_W     (PRIO_W),
        .ID_W       (ID_W),
        .START_CYC  (START_CYC),
        .STATUS_CYC (STATUS_CYC)
    ) u_dec (
        .cyc_num   (cyc_num),
        .cyc_valid (cyc_valid),
        .slot      (slot)
    );

    lpa_bit_pick #(.W(PRIO_W)) u_prio_pick (
        .val  (prio_key),
        .idx  (slot.idx),
        .pick (prio_pick)
    );

    lpa_bit_pick #(.W(ID_W)) u_id_pick (
        .val  (arb_id),
        .idx  (slot.idx),
        .pick (id_pick)
    );

    lpa_elim #(.ARB_LINE(ARB_LINE)) u_elim (
        .clk       (clk),
        .rst       (rst),
        .phase     (slot.phase),
        .last      (slot.last),
        .drive_bit (drive_bit),
        .slot_free (slot_free),
        .bus_in    (bus_in),
        .st        (st)
    );

    always_comb begin
        case (slot.phase)
            PH_PRIO: want = prio_pick;
            PH_TIE:  want = id_pick;
            default: want = 1'b0;
        endcase
        drive_bit = st.active & want & lpa_is_arb(slot.phase);
        drv_en    = '0;
        drv_en[ARB_LINE] = drive_bit;
        if (slot.phase == PH_ACK && st.win) begin
            drv_en = LPA_ACK_CODE;
        end
    end

    assign win    = st.win;
    assign accept = st.acc;

endmodule

// File: rtl/lpa_participant_chk.sv
module lpa_participant_chk
    import lpa_pkg::*;
#(
    parameter int CNT_W      = 6,
    parameter int START_CYC  = 1,
    parameter int PRIO_FIRST = 21,
    parameter int ACK_CYC    = 33,
    parameter int ARB_LINE   = 0
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] cyc_num,
    input logic             cyc_valid,
    input logic             arb_seen,
    input logic [1:0]       drv_en,
    input logic             win,
    input logic             accept
);

    logic in_arb;
    logic out_seen;

    assign in_arb = cyc_valid && cyc_num >= CNT_W'(PRIO_FIRST) && cyc_num < CNT_W'(ACK_CYC);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_seen <= 1'b0;
        end else if (cyc_valid && cyc_num == CNT_W'(START_CYC)) begin
            out_seen <= 1'b0;
        end else if (in_arb && !drv_en[ARB_LINE] && arb_seen) begin
            out_seen <= 1'b1;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!win && !accept)); // R1

    AST_OUT_STAYS_OUT: assert property (@(posedge clk) disable iff (rst)
        (in_arb && out_seen) |-> !drv_en[ARB_LINE]); // R5

    AST_WIN_NEEDS_CLEAN: assert property (@(posedge clk) disable iff (rst)
        win |-> !out_seen); // R5

    AST_WIN_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (win && !(cyc_valid && cyc_num == CNT_W'(START_CYC))) |=> win); // R6

    AST_ACK_ONLY_CODE: assert property (@(posedge clk) disable iff (rst)
        (drv_en != 2'b00 && !in_arb) |-> (cyc_valid && cyc_num == CNT_W'(ACK_CYC) && drv_en == LPA_ACK_CODE)); // R7

    AST_ACCEPT_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        accept |-> $past(cyc_valid && cyc_num == CNT_W'(ACK_CYC) && drv_en == LPA_ACK_CODE)); // R8

    AST_ACCEPT_PULSE: assert property (@(posedge clk) disable iff (rst)
        accept |=> !accept); // R8

    AST_IDLE_CYCLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (cyc_valid && cyc_num == CNT_W'(ACK_CYC + 1)) |-> drv_en == 2'b00); // R9

    AST_GAP_QUIET: assert property (@(posedge clk) disable iff (rst)
        !cyc_valid |-> drv_en == 2'b00); // R11

endmodule

bind lpa_participant lpa_participant_chk #(
    .CNT_W      (CNT_W),
    .START_CYC  (START_CYC),
    .PRIO_FIRST (PRIO_FIRST),
    .ACK_CYC    (ACK_CYC),
    .ARB_LINE   (ARB_LINE)
) i_lpa_chk (
    .clk       (clk),
    .rst       (rst),
    .cyc_num   (cyc_num),
    .cyc_valid (cyc_valid),
    .arb_seen  (bus_in[ARB_LINE]),
    .drv_en    (drv_en),
    .win       (win),
    .accept    (accept)
);

// File: tb/test_lpa_participant.sv
`timescale 1ns/1ps
module test_lpa_participant;

    logic       clk = 1'b0;
    logic       rst;
    logic [5:0] cyc_num;
    logic       cyc_valid;
    logic [7:0] prio;
    logic [3:0] arb_id;
    logic       slot_free;
    logic [1:0] bus_in;
    logic [1:0] drv_en;
    logic       win;
    logic       accept;
    logic [1:0] others;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    // wired-OR bus: this block plus the other units modelled by the bench
    assign bus_in = drv_en | others;

    lpa_participant i_lpa_participant (
        .clk       (clk),
        .rst       (rst),
        .cyc_num   (cyc_num),
        .cyc_valid (cyc_valid),
        .prio      (prio),
        .arb_id    (arb_id),
        .slot_free (slot_free),
        .bus_in    (bus_in),
        .drv_en    (drv_en),
        .win       (win),
        .accept    (accept)
    );

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input int c);
        if (c >= 21 && c <= 28) return "R3";
        if (c >= 29 && c <= 32) return "R4";
        if (c == 33)            return "R7";
        return "R9";
    endfunction

    // one full message; a competitor unit is modelled from the requirements
    task automatic run_msg(input string name, input logic [7:0] p, input logic [3:0] id,
                           input logic slot, input logic [1:0] stat, input logic comp_on,
                           input logic [7:0] cp, input logic [3:0] cid, input bit gaps,
                           input string req_end);
        logic ea, ca, ew, eb, cb, bus0, nea, nca;
        logic [1:0] exp_drv;
        ea = 1'b0; ca = 1'b0; ew = 1'b0;
        prio = p; arb_id = id; slot_free = slot;
        for (int c = 1; c <= 34; c++) begin
            @(negedge clk);
            cyc_num = 6'(c); cyc_valid = 1'b1;
            eb = 1'b0; cb = 1'b0;
            if (c >= 21 && c <= 28) begin
                eb = ea & ~p[28-c];
                cb = ca & ~cp[28-c];
            end else if (c >= 29 && c <= 32) begin
                eb = ea & id[32-c];
                cb = ca & cid[32-c];
            end
            others = 2'b00;
            if (c == 20) others = stat;
            else if (c >= 21 && c <= 32) others = {1'b0, cb};
            #1;
            if (c >= 21 && c <= 32) exp_drv = {1'b0, eb};
            else if (c == 33)       exp_drv = ew ? 2'b10 : 2'b00;
            else                    exp_drv = 2'b00;
            chk(req_of(c), $sformatf("%s drv_en cycle %0d", name, c), 8'(drv_en), 8'(exp_drv));
            if (c == 2)  chk("R10", {name, " win after cycle 1"}, 8'(win), 8'h0);
            if (c == 33) chk("R6", {name, " win in cycle 33"}, 8'(win), 8'(ew));
            if (c == 34) chk("R8", {name, " accept in cycle 34"}, 8'(accept), gaps ? 8'h0 : 8'(ew));
            // model update for the edge that ends this cycle
            bus0 = eb | cb;
            if (c == 20) begin
                ea = slot && (stat == 2'b11);
                ca = comp_on && (stat == 2'b11);
            end else if (c >= 21 && c <= 32) begin
                nea = ea & ~(~eb & bus0);
                nca = ca & ~(~cb & bus0);
                ea = nea; ca = nca;
            end
            if (c == 32) ew = ea;
            if (gaps) begin
                @(negedge clk);
                cyc_valid = 1'b0; others = 2'b00;
                #1;
                chk("R11", $sformatf("%s drv_en gap after %0d", name, c), 8'(drv_en), 8'h0);
                if (c == 33) chk("R8", {name, " accept in gap after 33"}, 8'(accept), 8'(ew));
            end
        end
        @(negedge clk);
        cyc_valid = 1'b0; others = 2'b00;
        #1;
        chk("R8", {name, " accept fell"}, 8'(accept), 8'h0);
        chk(req_end, {name, " final win"}, 8'(win), 8'(ew));
    endtask

    task automatic t_reset();
        rst = 1'b1; cyc_valid = 1'b0; cyc_num = '0; others = 2'b00;
        prio = '0; arb_id = '0; slot_free = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "reset win", 8'(win), 8'h0);
        chk("R1", "reset accept", 8'(accept), 8'h0);
        chk("R1", "reset drv_en", 8'(drv_en), 8'h0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_mid_reset();
        prio = 8'h00; arb_id = 4'hF; slot_free = 1'b1;
        for (int c = 1; c <= 22; c++) begin
            @(negedge clk);
            cyc_num = 6'(c); cyc_valid = 1'b1;
            others = (c == 20) ? 2'b11 : 2'b00;
        end
        @(negedge clk);
        cyc_valid = 1'b0; others = 2'b00; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        cyc_num = 6'd23; cyc_valid = 1'b1;
        #1;
        chk("R1", "drv_en after mid-contest reset", 8'(drv_en), 8'h0);
        chk("R1", "win after mid-contest reset", 8'(win), 8'h0);
        @(negedge clk);
        cyc_valid = 1'b0;
    endtask

    initial begin
        #1000000;
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        t_reset();
        run_msg("alone",      8'h10, 4'h5, 1'b1, 2'b11, 1'b0, 8'h00, 4'h0, 1'b0, "R6");
        run_msg("lower_prio", 8'h10, 4'h5, 1'b1, 2'b11, 1'b1, 8'h40, 4'h2, 1'b0, "R3");
        run_msg("higher_prio",8'h80, 4'h5, 1'b1, 2'b11, 1'b1, 8'h7F, 4'h2, 1'b0, "R5");
        run_msg("late_bit",   8'hA6, 4'h1, 1'b1, 2'b11, 1'b1, 8'hA5, 4'hE, 1'b0, "R5");
        run_msg("tie_win",    8'h33, 4'h9, 1'b1, 2'b11, 1'b1, 8'h33, 4'h6, 1'b0, "R4");
        run_msg("tie_lose",   8'h33, 4'h3, 1'b1, 2'b11, 1'b1, 8'h33, 4'hC, 1'b0, "R5");
        run_msg("no_slot",    8'h00, 4'h5, 1'b0, 2'b11, 1'b1, 8'h40, 4'h2, 1'b0, "R2");
        run_msg("bad_status", 8'h00, 4'h5, 1'b1, 2'b01, 1'b0, 8'h00, 4'h0, 1'b0, "R2");
        run_msg("gaps",       8'h21, 4'hA, 1'b1, 2'b11, 1'b1, 8'h21, 4'h8, 1'b1, "R11");
        run_msg("after_win",  8'hFF, 4'h0, 1'b1, 2'b11, 1'b1, 8'h01, 4'h0, 1'b0, "R10");
        t_mid_reset();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule